// File: doc/BRIEF.md
# Banked Memory Mapper with Snapshot Clock

This block decodes processor writes into the upper address regions of a cartridge-style memory map and keeps the bank selection a memory system needs. A 7-bit ROM bank number drives the switchable program window. The external RAM window either maps one of four RAM banks or exposes one of five real-time clock registers. The clock counts seconds, minutes, hours and a 9-bit day number. It advances on a one-cycle pulse per second and keeps an overflow flag that stays set.

Software cannot read the running counters directly. It first writes a zero and then a one to the latch region. This copies the whole clock into a snapshot, and every clock read returns that snapshot, so the fields agree with each other even across a tick. Writes through the window go to the running counters. The ROM and RAM arrays sit outside the block: it only supplies bank numbers and a RAM enable, and it drives the window read data itself whenever the RAM array does not own the window.

Top module: `bank_clock_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, RAM and clock access are off, no clock register is selected, the latched flag is clear, and all clock counters and the snapshot are zero.
- R2: A write with address bits 15:13 = 1 loads data bits 6:0 into the ROM bank. A value of 0 loads 1, so the ROM bank is never 0.
- R3: A write with address bits 15:13 = 0 enables window access for data 0x0A and disables it for data 0x00. Any other data leaves access unchanged. ram_enable is high exactly when access is on and a RAM bank (not a clock register) is selected.
- R4: A write with address bits 15:13 = 2 and data 0–3 sets the RAM bank to that value and deselects the clock. Data 0x08–0x0C selects clock register index data−8. Any other data changes nothing.
- R5: A write with address bits 15:13 = 3 and data 1, while not latched, copies all running counters into the snapshot and sets the latched flag. Data 0 while latched clears the flag. Every other such write has no effect. The snapshot changes at no other time.
- R6: While access is on and a clock register is selected, win_rdata shows the snapshot. Index 0 is seconds, 1 is minutes, 2 is hours, 3 is day bits 7:0. Index 4 is {overflow, halt, 5'b0, day bit 8}.
- R7: Each sec_tick pulse advances seconds 0–59. Its wrap carries into minutes 0–59, which carry into hours 0–23, which carry into the 9-bit day count.
- R8: A day carry out of 511 wraps the day to 0 and sets the overflow flag. The flag stays set until a write to index 4 with bit 7 clear.
- R9: While the halt bit (index 4, bit 6) is set, tick pulses do not change any counter.
- R10: A write with address bits 15:13 = 5, while access is on and a clock register is selected, loads the running counter for that index. Seconds and minutes keep 6 bits, hours keep 5 bits, and index 4 loads day bit 8, halt and overflow. A tick in the same cycle is dropped. The same write has no effect while access is off.
- R11: win_rdata is 0xFF whenever access is off or a RAM bank is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| cpu_we | input | 1 | Write strobe for one cycle |
| cpu_addr | input | 16 | Write/read address |
| cpu_wdata | input | 8 | Write data |
| rom_bank | output | 7 | Switchable ROM bank number |
| ram_bank | output | 2 | Selected RAM bank |
| ram_enable | output | 1 | RAM array owns the window |
| win_rdata | output | 8 | Window read data when the RAM array does not own it |

## Verification
The random phase mixes writes to all five regions and tick pulses. Region data is drawn from the meaningful codes and from arbitrary bytes, which separates decoded values from ignored ones. The phase also throws in window writes with out-of-range counter values, which expose wrong masking or wrap widths. Directed runs preload 23:59:59 on day 511 and tick once to show the full carry chain and the overflow flag. They also read the snapshot across later ticks to tell the latched copy apart from the live counters. Further runs tick with the halt bit set, and latch twice without the intervening zero, to confirm that the second latch is ignored.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
   localparam logic [2:0] RG_ENABLE = 3'd0;
   localparam logic [2:0] RG_ROM    = 3'd1;
   localparam logic [2:0] RG_SELECT = 3'd2;
   localparam logic [2:0] RG_LATCH  = 3'd3;
   localparam logic [2:0] RG_WINDOW = 3'd5;

   localparam int NUM_FIELDS = 4;
   localparam int CLK_REGS   = 5;
   localparam int IDX_W      = 3;

   localparam logic [7:0] CODE_ON  = 8'h0A;
   localparam logic [7:0] CODE_OFF = 8'h00;
   localparam logic [7:0] SEL_BASE = 8'h08;

   function automatic int field_max(input int i);
      case (i)
         0, 1:    return 59;
         2:       return 23;
         default: return 511;
      endcase
   endfunction

   function automatic int field_mask(input int i);
      case (i)
         0, 1:    return 63;
         2:       return 31;
         default: return 511;
      endcase
   endfunction
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
   import mapper_pkg::*;
#(
   parameter int ROM_W     = 7,
   parameter int RAM_BANKS = 4,
   localparam int RAM_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [2:0]       region,
   input  logic [7:0]       wdata,
   output logic [ROM_W-1:0] rom_bank,
   output logic [RAM_W-1:0] ram_bank,
   output logic             acc_en,
   output logic             clk_sel,
   output logic [IDX_W-1:0] clk_idx,
   output logic             capture
);
   logic latched_q;
   logic sel_ram, sel_clk;
   logic [7:0] idx_off;

   assign sel_ram = (int'(wdata) < RAM_BANKS);
   assign sel_clk = (wdata >= SEL_BASE) && (int'(wdata) < int'(SEL_BASE) + CLK_REGS);
   assign idx_off = wdata - SEL_BASE;
   assign capture = we && (region == RG_LATCH) && !latched_q && (wdata == 8'h01);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_bank  <= ROM_W'(1);
         ram_bank  <= '0;
         acc_en    <= 1'b0;
         clk_sel   <= 1'b0;
         clk_idx   <= '0;
         latched_q <= 1'b0;
      end else if (we) begin
         case (region)
            RG_ENABLE: begin
               if (wdata == CODE_ON)       acc_en <= 1'b1;
               else if (wdata == CODE_OFF) acc_en <= 1'b0;
            end
            RG_ROM: begin
               if (wdata[ROM_W-1:0] == '0) rom_bank <= ROM_W'(1);
               else                        rom_bank <= wdata[ROM_W-1:0];
            end
            RG_SELECT: begin
               if (sel_ram) begin
                  ram_bank <= wdata[RAM_W-1:0];
                  clk_sel  <= 1'b0;
               end else if (sel_clk) begin
                  clk_idx <= idx_off[IDX_W-1:0];
                  clk_sel <= 1'b1;
               end
            end
            RG_LATCH: begin
               if (capture)                             latched_q <= 1'b1;
               else if (latched_q && wdata == 8'h00)    latched_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
   parameter int W    = 9,
   parameter int MAXV = 59,
   parameter int MASK = 63
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] val,
   output logic         carry
);
   localparam logic [W-1:0] TOP = W'(MAXV);
   localparam logic [W-1:0] MSK = W'(MASK);

   assign carry = inc && (val == TOP);

   always_ff @(posedge clk) begin
      if (!rst_n)      val <= '0;
      else if (ld)     val <= ld_val & MSK;
      else if (carry)  val <= '0;
      else if (inc)    val <= (val + W'(1)) & MSK;
   end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
   import mapper_pkg::*;
#(
   parameter int DAY_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       wdata,
   output logic [5:0]       sec,
   output logic [5:0]       mins,
   output logic [4:0]       hrs,
   output logic [DAY_W-1:0] day,
   output logic             halt,
   output logic             ovf
);
   logic [DAY_W-1:0] fv   [NUM_FIELDS];
   logic [DAY_W-1:0] ldv  [NUM_FIELDS];
   logic             ld   [NUM_FIELDS];
   logic             inc  [NUM_FIELDS];
   logic             cy   [NUM_FIELDS];

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      if (i == 0) begin : g_first
         assign inc[i] = tick && !halt && !wr;
      end else begin : g_next
         assign inc[i] = cy[i-1];
      end
      if (i == NUM_FIELDS - 1) begin : g_day
         assign ld[i]  = wr && (idx == IDX_W'(3) || idx == IDX_W'(4));
         assign ldv[i] = (idx == IDX_W'(3)) ? {fv[i][DAY_W-1:8], wdata}
                                           : {wdata[DAY_W-9:0], fv[i][7:0]};
      end else begin : g_hms
         assign ld[i]  = wr && (idx == IDX_W'(i));
         assign ldv[i] = DAY_W'(wdata);
      end
      rtc_field #(
         .W    (DAY_W),
         .MAXV (field_max(i)),
         .MASK (field_mask(i))
      ) u_fld (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (inc[i]),
         .ld     (ld[i]),
         .ld_val (ldv[i]),
         .val    (fv[i]),
         .carry  (cy[i])
      );
   end

   assign sec  = fv[0][5:0];
   assign mins = fv[1][5:0];
   assign hrs  = fv[2][4:0];
   assign day  = fv[3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt <= 1'b0;
         ovf  <= 1'b0;
      end else if (wr && idx == IDX_W'(4)) begin
         halt <= wdata[6];
         ovf  <= wdata[7];
      end else if (cy[NUM_FIELDS-1]) begin
         ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/rtc_latch.sv
module rtc_latch
   import mapper_pkg::*;
#(
   parameter int DAY_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [5:0]       sec,
   input  logic [5:0]       mins,
   input  logic [4:0]       hrs,
   input  logic [DAY_W-1:0] day,
   input  logic             halt,
   input  logic             ovf,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       rd
);
   logic [7:0] snap [CLK_REGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < CLK_REGS; i++) snap[i] <= 8'h00;
      end else if (capture) begin
         snap[0] <= {2'b00, sec};
         snap[1] <= {2'b00, mins};
         snap[2] <= {3'b000, hrs};
         snap[3] <= day[7:0];
         snap[4] <= {ovf, halt, 5'b00000, day[8]};
      end
   end

   always_comb begin
      rd = 8'hFF;
      for (int i = 0; i < CLK_REGS; i++)
         if (idx == IDX_W'(i)) rd = snap[i];
   end
endmodule

// File: rtl/bank_clock_mapper.sv
module bank_clock_mapper
   import mapper_pkg::*;
#(
   parameter int ROM_W     = 7,
   parameter int RAM_BANKS = 4,
   parameter int DAY_W     = 9,
   localparam int RAM_W    = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_tick,
   input  logic             cpu_we,
   input  logic [15:0]      cpu_addr,
   input  logic [7:0]       cpu_wdata,
   output logic [ROM_W-1:0] rom_bank,
   output logic [RAM_W-1:0] ram_bank,
   output logic             ram_enable,
   output logic [7:0]       win_rdata
);
   if (DAY_W != 9) begin : g_bad_day
      $error("DAY_W must be 9: bit 8 lives in register index 4");
   end
   if (ROM_W < 1 || ROM_W > 8) begin : g_bad_rom
      $error("ROM_W must be 1..8");
   end
   if (RAM_BANKS < 1 || RAM_BANKS > 8) begin : g_bad_ram
      $error("RAM_BANKS must be 1..8 so select codes stay below 0x08");
   end

   logic [2:0]       region;
   logic             acc_en, clk_sel, capture, clk_wr;
   logic [IDX_W-1:0] clk_idx;
   logic [5:0]       sec_q, min_q;
   logic [4:0]       hrs_q;
   logic [DAY_W-1:0] day_q;
   logic             halt_q, ovf_q;
   logic [7:0]       snap_rd;

   assign region = cpu_addr[15:13];
   assign clk_wr = cpu_we && (region == RG_WINDOW) && acc_en && clk_sel;

   mapper_ctrl #(.ROM_W(ROM_W), .RAM_BANKS(RAM_BANKS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cpu_we),
      .region   (region),
      .wdata    (cpu_wdata),
      .rom_bank (rom_bank),
      .ram_bank (ram_bank),
      .acc_en   (acc_en),
      .clk_sel  (clk_sel),
      .clk_idx  (clk_idx),
      .capture  (capture)
   );

   rtc_core #(.DAY_W(DAY_W)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (sec_tick),
      .wr    (clk_wr),
      .idx   (clk_idx),
      .wdata (cpu_wdata),
      .sec   (sec_q),
      .mins  (min_q),
      .hrs   (hrs_q),
      .day   (day_q),
      .halt  (halt_q),
      .ovf   (ovf_q)
   );

   rtc_latch #(.DAY_W(DAY_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .sec     (sec_q),
      .mins    (min_q),
      .hrs     (hrs_q),
      .day     (day_q),
      .halt    (halt_q),
      .ovf     (ovf_q),
      .idx     (clk_idx),
      .rd      (snap_rd)
   );

   assign ram_enable = acc_en && !clk_sel;
   assign win_rdata  = (acc_en && clk_sel) ? snap_rd : 8'hFF;
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
   parameter int ROM_W = 7,
   parameter int RAM_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_we,
   input logic [15:0]      cpu_addr,
   input logic [7:0]       cpu_wdata,
   input logic [ROM_W-1:0] rom_bank,
   input logic [RAM_W-1:0] ram_bank,
   input logic             ram_enable,
   input logic [7:0]       win_rdata,
   input logic             halt_q,
   input logic             ovf_q,
   input logic [5:0]       sec_q
);
   a_r2_rom_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rom_bank != '0);

   a_r2_rom_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr[15:13] == 3'd1) |=>
      rom_bank == (($past(cpu_wdata[ROM_W-1:0]) == '0) ? ROM_W'(1) : $past(cpu_wdata[ROM_W-1:0])));

   a_r3_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr[15:13] == 3'd0 && cpu_wdata == 8'h00) |=> !ram_enable);

   a_r4_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr[15:13] == 3'd2 && cpu_wdata < 8'd4) |=>
      ram_bank == $past(cpu_wdata[RAM_W-1:0]));

   a_r5_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_we |=> $stable(win_rdata));

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !cpu_we) |=> ovf_q);

   a_r9_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !cpu_we) |=> $stable(sec_q));

   a_r11_ram_owns: assert property (@(posedge clk) disable iff (!rst_n)
      ram_enable |-> win_rdata == 8'hFF);
endmodule

bind bank_clock_mapper mapper_checker #(.ROM_W(ROM_W), .RAM_W(RAM_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_we     (cpu_we),
   .cpu_addr   (cpu_addr),
   .cpu_wdata  (cpu_wdata),
   .rom_bank   (rom_bank),
   .ram_bank   (ram_bank),
   .ram_enable (ram_enable),
   .win_rdata  (win_rdata),
   .halt_q     (halt_q),
   .ovf_q      (ovf_q),
   .sec_q      (sec_q)
);

// File: tb/sim_bank_clock_mapper.sv
`timescale 1ns/1ps
module sim_bank_clock_mapper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [6:0]  rom_bank;
   logic [1:0]  ram_bank;
   logic        ram_enable;
   logic [7:0]  win_rdata;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   bank_clock_mapper u0 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rom_bank(rom_bank),
      .ram_bank(ram_bank), .ram_enable(ram_enable), .win_rdata(win_rdata)
   );

   // reference model state
   logic [6:0] m_rom;
   logic [1:0] m_ram;
   logic       m_acc, m_sel, m_latched;
   logic [2:0] m_idx;
   logic [5:0] m_sec, m_min;
   logic [4:0] m_hr;
   logic [8:0] m_day;
   logic       m_halt, m_ovf;
   logic [7:0] s_reg [5];

   task automatic model_reset();
      m_rom = 7'd1; m_ram = '0; m_acc = 0; m_sel = 0; m_latched = 0; m_idx = '0;
      m_sec = '0; m_min = '0; m_hr = '0; m_day = '0; m_halt = 0; m_ovf = 0;
      for (int i = 0; i < 5; i++) s_reg[i] = 8'h00;
   endtask

   function automatic logic [7:0] exp_rd();
      if (!(m_acc && m_sel)) return 8'hFF;
      if (m_idx < 3'd5) return s_reg[m_idx];
      return 8'hFF;
   endfunction

   task automatic model_step(input bit we, input logic [15:0] a, input logic [7:0] d, input bit tk);
      logic [2:0] r;
      bit cw;
      r  = a[15:13];
      cw = we && r == 3'd5 && m_acc && m_sel;
      if (we) begin
         case (r)
            3'd0: if (d == 8'h0A) m_acc = 1; else if (d == 8'h00) m_acc = 0;
            3'd1: m_rom = (d[6:0] == 0) ? 7'd1 : d[6:0];
            3'd2: if (d < 8'd4) begin m_ram = d[1:0]; m_sel = 0; end
                  else if (d >= 8'd8 && d <= 8'd12) begin m_idx = 3'(d - 8'd8); m_sel = 1; end
            3'd3: if (!m_latched && d == 8'd1) begin
                     s_reg[0] = {2'b0, m_sec}; s_reg[1] = {2'b0, m_min};
                     s_reg[2] = {3'b0, m_hr};  s_reg[3] = m_day[7:0];
                     s_reg[4] = {m_ovf, m_halt, 5'b0, m_day[8]};
                     m_latched = 1;
                  end else if (m_latched && d == 8'd0) m_latched = 0;
            default: ;
         endcase
      end
      if (cw) begin
         case (m_idx)
            3'd0: m_sec = d[5:0];
            3'd1: m_min = d[5:0];
            3'd2: m_hr  = d[4:0];
            3'd3: m_day = {m_day[8], d};
            default: begin m_day[8] = d[0]; m_halt = d[6]; m_ovf = d[7]; end
         endcase
      end else if (tk && !m_halt) begin
         if (m_sec != 59) m_sec = m_sec + 1;
         else begin
            m_sec = 0;
            if (m_min != 59) m_min = m_min + 1;
            else begin
               m_min = 0;
               if (m_hr != 23) m_hr = m_hr + 1;
               else begin
                  m_hr = 0;
                  if (m_day != 9'd511) m_day = m_day + 1;
                  else begin m_day = 0; m_ovf = 1; end
               end
            end
         end
      end
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check(rom_bank == m_rom, {tag, " R2 rom_bank"}, rom_bank, m_rom);
      check(ram_bank == m_ram, {tag, " R4 ram_bank"}, ram_bank, m_ram);
      check(ram_enable == (m_acc && !m_sel), {tag, " R3 ram_enable"}, ram_enable, m_acc && !m_sel);
      check(win_rdata == exp_rd(), {tag, " R6 win_rdata"}, win_rdata, exp_rd());
   endtask

   task automatic cyc(input bit we, input logic [15:0] a, input logic [7:0] d, input bit tk);
      @(negedge clk);
      cpu_we = we; cpu_addr = a; cpu_wdata = d; sec_tick = tk;
      model_step(we, a, d, tk);
      @(posedge clk);
      #1;
      cpu_we = 0; sec_tick = 0;
   endtask

   task automatic wr(input logic [2:0] r, input logic [7:0] d);
      cyc(1, {r, 13'h0123}, d, 0);
   endtask

   task automatic rd_reg(input logic [2:0] idx, input logic [7:0] exp, input string tag);
      wr(3'd2, 8'd8 + 8'(idx));
      check(win_rdata == exp, tag, win_rdata, exp);
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #1;
      // R1 reset state
      check(rom_bank == 7'd1, "R1 rom_bank", rom_bank, 1);
      check(ram_bank == 2'd0, "R1 ram_bank", ram_bank, 0);
      check(ram_enable == 1'b0, "R1 ram_enable", ram_enable, 0);
      check(win_rdata == 8'hFF, "R1/R11 win_rdata", win_rdata, 8'hFF);

      // R2 zero maps to one, masking to 7 bits
      wr(3'd1, 8'h00); check(rom_bank == 7'd1, "R2 zero->1", rom_bank, 1);
      wr(3'd1, 8'h85); check(rom_bank == 7'd5, "R2 mask", rom_bank, 5);
      wr(3'd1, 8'h80); check(rom_bank == 7'd1, "R2 0x80->1", rom_bank, 1);

      // R10 clock write ignored while access off
      wr(3'd2, 8'h08);
      wr(3'd5, 8'd33);
      wr(3'd0, 8'h0A);
      wr(3'd3, 8'h00); wr(3'd3, 8'h01);
      check(win_rdata == 8'h00, "R10 write ignored when off", win_rdata, 0);
      // R3 odd enable code ignored
      wr(3'd0, 8'h05); check(win_rdata == 8'h00, "R3 ignored code keeps access", win_rdata, 0);
      // R4 out-of-range select ignored
      wr(3'd2, 8'h0D); check(win_rdata == 8'h00, "R4 ignored select", win_rdata, 0);

      // R7/R8 full carry chain: 23:59:59 day 511
      wr(3'd5, 8'd59); wr(3'd2, 8'h09); wr(3'd5, 8'd59);
      wr(3'd2, 8'h0A); wr(3'd5, 8'd23);
      wr(3'd2, 8'h0B); wr(3'd5, 8'hFF);
      wr(3'd2, 8'h0C); wr(3'd5, 8'h01);
      cyc(0, 16'h0, 8'h0, 1);
      wr(3'd3, 8'h00); wr(3'd3, 8'h01);
      check(win_rdata == 8'h80, "R8 overflow set, day8 clear", win_rdata, 8'h80);
      rd_reg(3'd0, 8'd0, "R7 sec wrapped");
      rd_reg(3'd2, 8'd0, "R7 hour wrapped");
      rd_reg(3'd3, 8'd0, "R7 day wrapped");

      // R5 snapshot holds across ticks and a second 1 without 0
      repeat (5) cyc(0, 16'h0, 8'h0, 1);
      rd_reg(3'd0, 8'd0, "R5 snapshot frozen");
      wr(3'd3, 8'h01);
      check(win_rdata == 8'd0, "R5 second latch ignored", win_rdata, 0);
      wr(3'd3, 8'h00); wr(3'd3, 8'h01);
      check(win_rdata == 8'd5, "R5 relatch shows 5", win_rdata, 5);

      // R8 overflow sticky through ticks, cleared by write
      rd_reg(3'd4, 8'h80, "R8 still set");
      // R9 halt
      wr(3'd5, 8'h40);
      repeat (4) cyc(0, 16'h0, 8'h0, 1);
      wr(3'd3, 8'h00); wr(3'd3, 8'h01);
      check(win_rdata == 8'h40, "R8 cleared R9 halt set", win_rdata, 8'h40);
      rd_reg(3'd0, 8'd5, "R9 halted seconds");
      // R10 tick dropped on clock write cycle
      wr(3'd2, 8'h0C); wr(3'd5, 8'h00);
      wr(3'd2, 8'h08);
      cyc(1, 16'hA000, 8'd10, 1);
      wr(3'd3, 8'h00); wr(3'd3, 8'h01);
      check(win_rdata == 8'd10, "R10 write wins over tick", win_rdata, 10);
      // R11 RAM bank selected
      wr(3'd2, 8'h02);
      check(win_rdata == 8'hFF && ram_enable, "R11 RAM owns window", win_rdata, 8'hFF);
      check_all("directed");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [2:0] r;
         int k;
         k = int'($urandom % 5);
         r = (k == 4) ? 3'd5 : 3'(k);
         case (r)
            3'd0: d = ($urandom % 3 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h0A : 8'h00);
            3'd2: d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 13);
            3'd3: d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 2);
            3'd5: d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 60) & 8'h3F;
            default: d = 8'($urandom);
         endcase
         cyc($urandom % 3 != 0, {r, 13'($urandom)}, d, $urandom % 3 == 0);
         check_all("random");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule